// File: doc/BRIEF.md
# Saturating Cache Event Counter Unit

This block is a compact performance-monitoring unit attached to a cache controller. It holds a parameterised number of identical event counters, two by default and 32 bits each. Each counter has a configuration register that picks one of up to fifteen single-cycle event strobes from the cache. It also has a value register that software can read at any time and overwrite, for example to restart a count from zero.

A shared control register holds a global enable. A counter advances by one on each clock edge where the global enable is set, its selected source is a code that counts, and that source's strobe is high. Counters never wrap. Once a counter reaches all-ones it stays there, so an overrun shows up as a pinned value and not as a small wrapped number. Software is expected to poll and clear the counters well before that point.

The per-counter registers are placed in descending order. The highest-numbered counter takes the lowest address of each bank.

Top module: `cache_evt_counter_unit`

## Requirements
- R1: After reset, the control register, every configuration register and every counter read as zero.
- R2: The register map is as follows. Control is at offset 0x00, with the enable at bit 0. The configuration registers are Counter1 at 0x04 and Counter0 at 0x08. The value registers are Counter1 at 0x0C and Counter0 at 0x10. A configuration register keeps the source code in bits [5:2] and the interrupt-disable flag in bit 0, and its other bits read as zero.
- R3: While the global enable is clear, no counter changes on events, whatever its source code.
- R4: Source code 0 is the disabled code, and a counter set to it never counts, even when every strobe is high.
- R5: With the enable set and source code k (1 to 9), each clock edge with strobe bit k high adds exactly one to the counter. Strobes of other codes have no effect.
- R6: A counter at 0xFFFFFFFF stays at 0xFFFFFFFF on further events.
- R7: Codes 0xA to 0xF count like the others when parameter EXT_EVENTS is 1, and behave as the disabled code when it is 0.
- R8: A write to a value register loads that counter on the next edge. When it coincides with a counted event, the written value wins and the event is dropped.
- R9: Reads of an unmapped offset return zero, and writes to one change no register.
- R10: The counters are independent: each follows only its own source selection and its own value writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| evt_strobe | input | 16 | Event strobes; bit k is the event with source code k, bit 0 is unused |

## Verification
Register writes and event strobes are sampled on a rising edge, so their effect is due one edge later. Read data is a combinational function of the address and of the registers, so it is due in the same cycle. The bench changes every input at a falling edge. It reads by setting the address at a falling edge and sampling reg_rdata shortly afterwards. Each result is therefore observed exactly one edge after its stimulus, and never at a clock edge.

// File: rtl/cev_pkg.sv
package cev_pkg;
  localparam int SRC_W    = 4;
  localparam int NUM_SRC  = 1 << SRC_W;
  localparam int BASE_MAX = 9;
  localparam int SRC_LSB  = 2;
  localparam int INTD_BIT = 0;

  typedef logic [SRC_W-1:0] src_t;

  // Whether a source code counts at all for the chosen variant
  function automatic logic src_counts(input src_t s, input bit ext);
    return (s != '0) && (ext || (int'(s) <= BASE_MAX));
  endfunction
endpackage

// File: rtl/cev_evt_select.sv
module cev_evt_select #(
  parameter bit EXT_EVENTS = 1'b1
) (
  input  cev_pkg::src_t                 src,
  input  logic [cev_pkg::NUM_SRC-1:0]   strobes,
  output logic                          hit
);
  logic code_live;

  assign code_live = cev_pkg::src_counts(src, EXT_EVENTS);
  assign hit       = code_live && strobes[src];
endmodule

// File: rtl/cev_sat_counter.sv
module cev_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == ALL_ONES) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (wr_en)    cnt_q <= wr_data;
    else if (count_en) cnt_q <= sat_inc(cnt_q);
  end

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == ALL_ONES && !wr_en) |=> (cnt_q == ALL_ONES));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !wr_en) |=> $stable(cnt_q));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !wr_en && cnt_q != ALL_ONES) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R8
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)));
endmodule

// File: rtl/cache_evt_counter_unit.sv
module cache_evt_counter_unit #(
  parameter int NUM_CTR    = 2,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter bit EXT_EVENTS = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [CNT_W-1:0]             reg_wdata,
  output logic [CNT_W-1:0]             reg_rdata,
  input  logic [cev_pkg::NUM_SRC-1:0]  evt_strobe
);
  localparam int CTRL_OFS = 0;
  localparam int CFG_BASE = 4;
  localparam int VAL_BASE = CFG_BASE + 4 * NUM_CTR;

  logic                 ctrl_en_q;
  logic                 ctrl_sel;
  logic [NUM_CTR-1:0]   cfg_sel;
  logic [NUM_CTR-1:0]   val_sel;
  logic [NUM_CTR-1:0]   hit;
  logic                 mapped;
  cev_pkg::src_t        cfg_src_q  [NUM_CTR];
  logic                 cfg_intd_q [NUM_CTR];
  logic [CNT_W-1:0]     cnt        [NUM_CTR];

  assign ctrl_sel = (reg_addr == ADDR_W'(CTRL_OFS));
  assign mapped   = ctrl_sel || (|cfg_sel) || (|val_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctrl_en_q <= 1'b0;
    else if (reg_wr && ctrl_sel) ctrl_en_q <= reg_wdata[0];
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    // descending layout: highest counter at lowest offset
    localparam int SLOT = NUM_CTR - 1 - i;
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_BASE + 4 * SLOT);
    localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(VAL_BASE + 4 * SLOT);

    assign cfg_sel[i] = (reg_addr == CFG_A);
    assign val_sel[i] = (reg_addr == VAL_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_src_q[i]  <= '0;
        cfg_intd_q[i] <= 1'b0;
      end else if (reg_wr && cfg_sel[i]) begin
        cfg_src_q[i]  <= reg_wdata[cev_pkg::SRC_LSB +: cev_pkg::SRC_W];
        cfg_intd_q[i] <= reg_wdata[cev_pkg::INTD_BIT];
      end
    end

    cev_evt_select #(.EXT_EVENTS(EXT_EVENTS)) u_sel (
      .src     (cfg_src_q[i]),
      .strobes (evt_strobe),
      .hit     (hit[i])
    );

    cev_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (ctrl_en_q && hit[i]),
      .wr_en    (reg_wr && val_sel[i]),
      .wr_data  (reg_wdata),
      .cnt_q    (cnt[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_sel) reg_rdata[0] = ctrl_en_q;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (cfg_sel[k]) begin
        reg_rdata[cev_pkg::SRC_LSB +: cev_pkg::SRC_W] = cfg_src_q[k];
        reg_rdata[cev_pkg::INTD_BIT]                  = cfg_intd_q[k];
      end
      if (val_sel[k]) reg_rdata = cnt[k];
    end
  end

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mapped) |=> $stable(ctrl_en_q));
endmodule

// File: tb/cache_evt_counter_unit_test.sv
`timescale 1ns/1ps
module cache_evt_counter_unit_test;
  localparam int NV = 7;
  localparam logic [3:0]  V_SRC  [NV] = '{4'h1, 4'h5, 4'h9, 4'h2, 4'h0, 4'hF, 4'h7};
  localparam logic [15:0] V_MASK [NV] = '{16'h0002, 16'h0020, 16'h0200, 16'h0008,
                                          16'hFFFF, 16'h8000, 16'hFFFF};
  localparam int          V_N    [NV] = '{5, 3, 7, 4, 4, 2, 6};
  localparam int          V_EXP  [NV] = '{5, 3, 7, 0, 0, 2, 6};

  localparam logic [7:0] A_CTRL = 8'h00, A_CFG1 = 8'h04, A_CFG0 = 8'h08,
                         A_VAL1 = 8'h0C, A_VAL0 = 8'h10, A_NONE = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, rdata_base;
  logic [15:0] evt_strobe = '0;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  cache_evt_counter_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe));

  cache_evt_counter_unit #(.EXT_EVENTS(1'b0)) uut_base (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_base), .evt_strobe(evt_strobe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] m, input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      evt_strobe = m;
    end
    @(negedge clk);
    evt_strobe = '0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R9 unmapped read
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_CFG1, d); check("R1 cfg1", d, 0);
    rd(A_CFG0, d); check("R1 cfg0", d, 0);
    rd(A_VAL1, d); check("R1 val1", d, 0);
    rd(A_VAL0, d); check("R1 val0", d, 0);
    rd(A_NONE, d); check("R9 unmapped read", d, 0);

    // vector table: R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      wr(A_CTRL, 0);
      wr(A_VAL0, 0);
      wr(A_CFG0, {26'd0, V_SRC[v], 2'b01});
      wr(A_CTRL, 1);
      pulse(V_MASK[v], V_N[v]);
      wr(A_CTRL, 0);
      rd(A_VAL0, d);
      check($sformatf("R5/R4/R7 vector %0d", v), d, V_EXP[v]);
    end

    // R2 field layout and readback
    wr(A_CFG1, 32'hFFFF_FFFF);
    rd(A_CFG1, d); check("R2 cfg readback", d, 32'h0000_003D);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check("R2 ctrl readback", d, 1);

    // R9 unmapped write
    wr(A_CTRL, 0);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_NONE, d); check("R9 unmapped write read", d, 0);
    rd(A_CTRL, d); check("R9 ctrl untouched", d, 0);

    // R3 enable gating
    wr(A_VAL0, 0);
    wr(A_CFG0, 32'h4);
    pulse(16'hFFFF, 3);
    rd(A_VAL0, d); check("R3 disabled no count", d, 0);

    // R6 saturation
    wr(A_VAL0, 32'hFFFF_FFFD);
    wr(A_CTRL, 1);
    pulse(16'h0002, 5);
    rd(A_VAL0, d); check("R6 saturate", d, 32'hFFFF_FFFF);

    // R8 write priority over event
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_VAL0; reg_wdata = 32'd5; evt_strobe = 16'h0002;
    @(negedge clk);
    reg_wr = 1'b0; evt_strobe = '0;
    rd(A_VAL0, d); check("R8 write wins", d, 5);
    wr(A_VAL0, 32'h0000_1234);
    rd(A_VAL0, d); check("R8 plain write", d, 32'h0000_1234);

    // R10 independence, R2 descending placement
    wr(A_CTRL, 0);
    wr(A_VAL0, 0);
    wr(A_VAL1, 0);
    wr(A_CFG1, 2 << 2);
    wr(A_CFG0, 3 << 2);
    wr(A_CTRL, 1);
    pulse(16'h000C, 4);
    pulse(16'h0004, 2);
    wr(A_CTRL, 0);
    rd(A_VAL1, d); check("R10 counter1 at 0x0C", d, 6);
    rd(A_VAL0, d); check("R10 counter0 at 0x10", d, 4);
    wr(A_VAL1, 32'h0000_00AA);
    rd(A_VAL0, d); check("R10 write isolation", d, 4);

    // R7 variant without extended codes
    wr(A_VAL0, 0);
    wr(A_CFG0, 32'hB << 2);
    wr(A_CTRL, 1);
    pulse(16'h0800, 3);
    wr(A_CTRL, 0);
    rd(A_VAL0, d); check("R7 extended counts", d, 3);
    #0 d = rdata_base; check("R7 base variant ignores 0xB", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule